// File: doc/BRIEF.md
# Zero-Suppressed Hit Formatter and Event Buffer

This block is the digital back end of a self-triggered multi-channel front-end. Each time the converter reports a hit, the block compares the amplitude with a programmable threshold. A hit at or below the threshold is discarded at once. A hit above it is packed into one 32-bit event word, which also holds the crossing identifier, the gain range and the channel number.

Packed words wait in an on-chip first-in first-out buffer. During acquisition nothing leaves the block. When the readout enable is raised, the buffer is drained through a valid/ready output. If the buffer is full when another qualifying hit arrives, that hit is lost. A saturating counter records how many hits were lost this way, so that the readout side can see the losses.

Top module: `hit_packer`

## Requirements
- R1: The event word is `{gain[1:0], channel[5:0], crossing[11:0], amplitude[11:0]}`. The gain sits in bits 31:30, the channel in 29:24, the crossing identifier in 23:12 and the amplitude in 11:0.
- R2: A hit presented with `hit_valid` high is stored only when its amplitude is strictly greater than `thresh`. A hit whose amplitude equals the threshold, or is below it, is discarded.
- R3: While `hit_valid` is low, the amplitude, gain, channel and crossing inputs have no effect on the buffer.
- R4: Stored words leave in the order they were accepted. `out_data` stays unchanged while `out_valid` is high and `out_ready` is low.
- R5: `out_valid` is high only while `readout_en` is high and the buffer holds at least one word. A word is removed only on a cycle in which both `out_valid` and `out_ready` are high.
- R6: When the buffer holds `FIFO_DEPTH` words, a qualifying hit is dropped and the stored contents are left intact. This holds even if a word is read out in the same cycle.
- R7: `lost_count` rises by one for each qualifying hit dropped because the buffer is full. It holds at its maximum value, 2^`LOST_W`−1.
- R8: After a clock edge with `rst_n` low, the buffer is empty, `out_valid` is low and `lost_count` is zero.
- R9: A write and a read in the same cycle on a buffer that is not full both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| thresh | input | 12 | Zero-suppression threshold |
| hit_valid | input | 1 | Hit strobe, one hit per cycle |
| hit_adc | input | 12 | Converted amplitude |
| hit_gain | input | 2 | Gain-range code |
| hit_chan | input | 6 | Channel number |
| hit_bx | input | 12 | Crossing identifier |
| readout_en | input | 1 | High during the readout phase |
| out_valid | output | 1 | Event word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Packed event word |
| lost_count | output | LOST_W | Saturating count of hits dropped on a full buffer |

## Verification
Assertions check on every cycle that a hit at or below threshold, or one without a strobe, never writes the buffer. They also check that the buffer is never written when full nor read when empty, that a word held back by the consumer stays stable, that no word is offered outside readout, and that the lost counter steps and saturates correctly. Some behaviour only the bench scenarios can show: the exact bit placement of each field, the first-in first-out order over many words, the equality case at several threshold settings including zero and the maximum, and saturation after hundreds of drops. The bench shows these by comparing every cycle with a queue-based model.

// File: rtl/hp_pkg.sv
// Shared widths and the event word layout for the hit formatter.
// Assumes one fixed 32-bit word with no chip identifier field.
package hp_pkg;
    localparam int ADC_W  = 12;
    localparam int BX_W   = 12;
    localparam int GAIN_W = 2;
    localparam int CHAN_W = 6;
    localparam int WORD_W = ADC_W + BX_W + GAIN_W + CHAN_W;

    // Field order from MSB: gain, channel, crossing, amplitude
    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic [CHAN_W-1:0] chan;
        logic [BX_W-1:0]   bx;
        logic [ADC_W-1:0]  adc;
    } hit_word_t;
endpackage

// File: rtl/hp_filter.sv
// Threshold comparator and word packer.
// Purely combinational; the caller registers the result into the buffer.
// Assumes amplitude and threshold are unsigned.
module hp_filter
    import hp_pkg::*;
(
    input  logic              hit_valid,
    input  logic [ADC_W-1:0]  hit_adc,
    input  logic [GAIN_W-1:0] hit_gain,
    input  logic [CHAN_W-1:0] hit_chan,
    input  logic [BX_W-1:0]   hit_bx,
    input  logic [ADC_W-1:0]  thresh,
    output logic              keep,
    output hit_word_t         word
);
    // Keep strobed hits strictly above threshold
    always_comb keep = hit_valid && (hit_adc > thresh);

    // Pack the fields into the event word
    always_comb begin
        word.gain = hit_gain;
        word.chan = hit_chan;
        word.bx   = hit_bx;
        word.adc  = hit_adc;
    end
endmodule

// File: rtl/hp_fifo.sv
// Synchronous first-word-fall-through buffer.
// The head word is on rd_data whenever empty is low.
// Assumes DEPTH >= 2 and that the caller never writes when full or reads when empty.
module hp_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    // Status flags from occupancy
    always_comb begin
        full  = (count == CW'(DEPTH));
        empty = (count == '0);
    end

    always_comb rd_data = mem[rd_ptr];

    // Store the incoming word
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/hp_lost_ctr.sv
// Saturating counter of hits dropped on a full buffer.
// Assumes at most one increment per cycle.
module hp_lost_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = '1;

    // Count up, stopping at the top value
    always_ff @(posedge clk) begin
        if (!rst_n)                     count <= '0;
        else if (inc && count != MAXV)  count <= count + 1'b1;
    end

    // R7
    lost_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count != MAXV) |=> count == $past(count) + 1'b1);

    // R7
    lost_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAXV) |=> count == MAXV);

    // R7
    lost_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));
endmodule

// File: rtl/hit_packer.sv
// Top of the zero-suppressed hit formatter.
// Filters hits against the threshold, packs survivors, buffers them and
// offers them on a valid/ready port only while readout is enabled.
// Assumes at most one hit per cycle; a hit meeting a full buffer is lost.
module hit_packer
    import hp_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int LOST_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADC_W-1:0]  thresh,
    input  logic              hit_valid,
    input  logic [ADC_W-1:0]  hit_adc,
    input  logic [GAIN_W-1:0] hit_gain,
    input  logic [CHAN_W-1:0] hit_chan,
    input  logic [BX_W-1:0]   hit_bx,
    input  logic              readout_en,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [LOST_W-1:0] lost_count
);
    logic      keep, fifo_wr, fifo_rd, fifo_full, fifo_empty, drop_full;
    hit_word_t word;

    hp_filter u_filter (
        .hit_valid (hit_valid),
        .hit_adc   (hit_adc),
        .hit_gain  (hit_gain),
        .hit_chan  (hit_chan),
        .hit_bx    (hit_bx),
        .thresh    (thresh),
        .keep      (keep),
        .word      (word)
    );

    // Route kept hits to the buffer or to the loss counter
    always_comb begin
        fifo_wr   = keep && !fifo_full;
        drop_full = keep && fifo_full;
    end

    // Offer the head word only during readout
    always_comb begin
        out_valid = readout_en && !fifo_empty;
        fifo_rd   = out_valid && out_ready;
    end

    hp_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fifo_wr),
        .wr_data (word),
        .rd_en   (fifo_rd),
        .rd_data (out_data),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    hp_lost_ctr #(.W(LOST_W)) u_lost (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (drop_full),
        .count (lost_count)
    );

    // R2
    below_thr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && hit_adc <= thresh) |-> !fifo_wr);

    // R3
    no_strobe_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> hit_valid);

    // R4
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_data));

    // R5
    quiet_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !readout_en |-> !out_valid);
endmodule

// File: tb/hit_packer_test.sv
module hit_packer_test;
    localparam int DEPTH = 8;
    localparam int LW    = 8;
    localparam int LMAX  = (1 << LW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] thresh = '0;
    logic        hit_valid = 1'b0;
    logic [11:0] hit_adc = '0;
    logic [1:0]  hit_gain = '0;
    logic [5:0]  hit_chan = '0;
    logic [11:0] hit_bx = '0;
    logic        readout_en = 1'b0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic [LW-1:0] lost_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string scen = "R8 reset";

    logic [31:0] q[$];
    int lost = 0;

    always #5 clk = ~clk;

    hit_packer #(.FIFO_DEPTH(DEPTH), .LOST_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .thresh(thresh), .hit_valid(hit_valid),
        .hit_adc(hit_adc), .hit_gain(hit_gain), .hit_chan(hit_chan),
        .hit_bx(hit_bx), .readout_en(readout_en), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .lost_count(lost_count)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%h expected=%h", tag, scen, act, exp);
        end
    endtask

    // One clock: model the edge from the inputs present before it, then compare
    task automatic step();
        bit mvalid, pop, kp, push, linc, rs;
        logic [31:0] w;
        rs     = rst_n;
        mvalid = readout_en && (q.size() > 0);
        pop    = mvalid && out_ready;
        kp     = hit_valid && (hit_adc > thresh);
        push   = kp && (q.size() < DEPTH);
        linc   = kp && (q.size() == DEPTH);
        w      = {hit_gain, hit_chan, hit_bx, hit_adc};   // R1 layout
        @(posedge clk);
        #2;
        if (!rs) begin
            q.delete();
            lost = 0;
        end else begin
            if (pop) void'(q.pop_front());
            if (push) q.push_back(w);
            if (linc && lost < LMAX) lost++;
        end
        chk("R5 out_valid", {31'b0, out_valid}, {31'b0, readout_en && q.size() > 0});
        if (readout_en && q.size() > 0) chk("R1 R4 out_data", out_data, q[0]);
        chk("R6 R7 lost_count", {{(32-LW){1'b0}}, lost_count}, lost);
    endtask

    task automatic hit(bit v, int adc, int g, int ch, int bx);
        hit_valid = v;
        hit_adc   = 12'(adc);
        hit_gain  = 2'(g);
        hit_chan  = 6'(ch);
        hit_bx    = 12'(bx);
        step();
    endtask

    task automatic idle(int n);
        hit_valid = 1'b0;
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        // R8: reset state
        readout_en = 1'b1;
        out_ready  = 1'b1;
        idle(3);
        chk("R8 reset valid", {31'b0, out_valid}, 32'd0);
        chk("R8 reset lost", {{(32-LW){1'b0}}, lost_count}, 32'd0);
        rst_n = 1'b1;
        readout_en = 1'b0;
        idle(1);

        // R2 R3: threshold edges during acquisition, nothing offered (R5)
        scen = "R2 R3 threshold";
        thresh = 12'h200;
        hit(1, 12'h200, 1, 5, 100);    // equal: dropped
        hit(1, 12'h201, 2, 63, 4095);  // just above: kept
        hit(1, 12'h1FF, 3, 1, 7);      // below: dropped
        hit(1, 12'hFFF, 0, 0, 0);      // max: kept
        hit(0, 12'hFFF, 3, 33, 555);   // no strobe: ignored
        hit(1, 0, 1, 2, 3);            // zero: dropped
        idle(3);

        // R4 R5: drain with stalls
        scen = "R4 R5 drain";
        readout_en = 1'b1;
        out_ready = 1'b0; idle(3);
        out_ready = 1'b1; idle(1);
        out_ready = 1'b0; idle(2);
        out_ready = 1'b1; idle(3);

        // R2: threshold at zero and at maximum
        scen = "R2 zero threshold";
        thresh = 12'h000;
        hit(1, 0, 1, 9, 9);
        hit(1, 1, 2, 10, 10);
        scen = "R2 max threshold";
        thresh = 12'hFFF;
        hit(1, 12'hFFF, 3, 11, 11);
        idle(3);

        // R9: write and read in the same cycle
        scen = "R9 concurrent";
        thresh = 12'h100;
        for (int i = 0; i < 12; i++)
            hit(1, 12'h101 + i * 13, i, i * 7, i * 37 + 5);
        idle(4);

        // R6 R7: overflow and saturation while readout is off
        scen = "R6 R7 overflow";
        readout_en = 1'b0;
        for (int i = 0; i < DEPTH + 300; i++)
            hit(1, 12'h300 + (i % 100), i + 1, i * 3, i);
        idle(2);
        // R6: reading and a hit in the same cycle on a full buffer
        readout_en = 1'b1;
        out_ready  = 1'b1;
        hit(1, 12'hABC, 2, 44, 1234);
        idle(DEPTH + 3);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog [%s] actual=timeout expected=finish", scen);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule